// File: doc/BRIEF.md
# Split cascadable compare timer

This block is a timer built from two count stages: a 4-bit low stage and an 8-bit high stage. Each stage owns a compare register. A mode input chooses how the stages work together. In split mode each stage counts enabled clocks on its own and compares against its own register. In cascaded mode the stages form one 12-bit counter. The low register supplies compare bits 3..0 and the high register supplies bits 11..4 of one 12-bit compare value.

A compare hit reloads the counter that matched on the same clock edge, so a count period spans the compare value plus one enabled clock. Every event appears one cycle later as a single registered pulse. The block has one pulse output per stage, an interrupt request, and a stage clock that shows when the next stage is stepped. A write to a compare register cancels any hit that same register would have produced in that cycle. The surrounding chip supplies the count enable (for example from a prescaler) and drives the write strobes from its register decoding.

Top module: `split_cmp_timer`

## Requirements
- R1: Reset (rstN low, asynchronous) clears both counters, sets the low compare register to 0xF and the high compare register to 0xFF, and holds every output low.
- R2: When wrLo is high at a clock edge, the low compare register takes wrData[3:0]. When wrHi is high, the high compare register takes wrData[7:0]. The new value is used for comparison from the next cycle on.
- R3: In split mode (cascade = 0), each stage adds one on every edge where cntEn is high. On an enabled edge where a stage's count equals its compare value, that stage reloads to 0 instead, so its period is compare value + 1. matchLo or matchHi is then high for exactly the following cycle.
- R4: When cntEn is low at an edge, both counters hold their values and none of matchLo, matchHi, irq or stageClk pulses in the next cycle.
- R5: In split mode, stageClk pulses in the cycle after each low-stage hit, and irq pulses in the cycle after an edge on which either stage hit. Simultaneous hits give one irq pulse.
- R6: In cascade mode (cascade = 1), the low stage counts every enabled edge and wraps from 15 to 0. The high stage adds one only on an enabled edge where the low stage is at 15 and no 12-bit hit occurs. stageClk pulses in the cycle after each such high-stage step.
- R7: In cascade mode, when the 12-bit count {high, low} equals {high register, low register} on an enabled edge, both stages reload to 0. matchHi and irq then pulse in the next cycle, so the period is the 12-bit value + 1. matchLo never pulses in this mode.
- R8: A write to a compare register cancels a hit in that same cycle. In split mode a write to a stage's register cancels only that stage's hit. In cascade mode a write to either register cancels the 12-bit hit. A cancelled stage does not pulse, and it counts on (incrementing and wrapping) as if no hit had occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count enable, one step per high cycle |
| cascade | input | 1 | 1 = joined 12-bit counter, 0 = two independent stages |
| wrLo | input | 1 | Write strobe for the low compare register |
| wrHi | input | 1 | Write strobe for the high compare register |
| wrData | input | 8 | Write data; the low register takes bits 3..0 |
| matchLo | output | 1 | Low-stage hit pulse (split mode only) |
| matchHi | output | 1 | High-stage hit pulse, or 12-bit hit pulse in cascade mode |
| irq | output | 1 | Interrupt request pulse |
| stageClk | output | 1 | Pulse marking each step given to the next stage |

## Verification
The bench aims at a compare value of zero, where a hit occurs on every enabled clock. A design that delays the reload by a cycle would give a period of two instead of one. The bench places register writes exactly on hit cycles, in both modes. A design that ignored the cancel rule would emit a spurious pulse, and a design that cancelled the wrong stage would lose a genuine one. It also checks that the counter climbs past the compare value and wraps around before the next hit. In cascade mode the bench crosses the low-stage wrap many times, runs a 12-bit value whose high part is non-zero, and toggles the count enable irregularly. A carry taken from the wrong condition, or a hit that checks only one stage, would shift every later pulse. Both stages are also given equal periods, so that a design issuing two interrupt pulses for coincident hits is exposed.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic ldLo;   // load low compare register
    logic ldHi;   // load high compare register
    logic clrLo;  // reload low counter to zero
    logic incLo;  // advance low counter
    logic clrHi;  // reload high counter to zero
    logic incHi;  // advance high counter
  } sctStrobe_t;

endpackage

// File: rtl/sct_stage.sv
`timescale 1ns/1ps
module sct_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         eq
);

  logic [W-1:0] cmpReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      cmpReg <= '1;
    end else begin
      if (ld) cmpReg <= ldVal;
      if (clr)      cnt <= '0;
      else if (inc) cnt <= cnt + W'(1);
    end
  end

  assign eq = (cnt == cmpReg);

  // R2: a written value is what the stage compares against next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    ld |=> (eq == (cnt == $past(ldVal))));

  // R4: without a strobe the count stays put
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/sct_datapath.sv
`timescale 1ns/1ps
module sct_datapath
  import sct_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  sctStrobe_t      str,
  input  logic [HI_W-1:0] wrData,
  output logic            eqLo,
  output logic            eqHi,
  output logic            topLo
);

  logic [LO_W-1:0] loCnt;
  logic [HI_W-1:0] hiCnt;

  sct_stage #(.W(LO_W)) uLo (
    .clk   (clk),
    .rstN  (rstN),
    .ld    (str.ldLo),
    .ldVal (wrData[LO_W-1:0]),
    .clr   (str.clrLo),
    .inc   (str.incLo),
    .cnt   (loCnt),
    .eq    (eqLo)
  );

  sct_stage #(.W(HI_W)) uHi (
    .clk   (clk),
    .rstN  (rstN),
    .ld    (str.ldHi),
    .ldVal (wrData),
    .clr   (str.clrHi),
    .inc   (str.incHi),
    .cnt   (hiCnt),
    .eq    (eqHi)
  );

  assign topLo = &loCnt;

  // R3: a reload lands on zero
  p_reload_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    str.clrLo |=> (loCnt == '0));

  // R3/R8: an advance adds exactly one, wrapping at the stage width
  p_step_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.incLo && !str.clrLo) |=> (loCnt == LO_W'($past(loCnt) + 1)));

  // R6: the high stage also steps by exactly one
  p_step_hi_r6: assert property (@(posedge clk) disable iff (!rstN)
    (str.incHi && !str.clrHi) |=> (hiCnt == HI_W'($past(hiCnt) + 1)));

endmodule

// File: rtl/sct_ctrl.sv
`timescale 1ns/1ps
module sct_ctrl
  import sct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntEn,
  input  logic       cascade,
  input  logic       wrLo,
  input  logic       wrHi,
  input  logic       eqLo,
  input  logic       eqHi,
  input  logic       topLo,
  output sctStrobe_t str,
  output logic       matchLo,
  output logic       matchHi,
  output logic       irq,
  output logic       stageClk
);

  logic hitLo, hitHi, hitFull, advHi;

  always_comb begin
    str      = '0;
    str.ldLo = wrLo;
    str.ldHi = wrHi;
    hitLo    = 1'b0;
    hitHi    = 1'b0;
    hitFull  = 1'b0;
    advHi    = 1'b0;
    if (cascade) begin
      hitFull   = cntEn && eqLo && eqHi && !wrLo && !wrHi;
      advHi     = cntEn && topLo && !hitFull;
      str.clrLo = hitFull;
      str.clrHi = hitFull;
      str.incLo = cntEn && !hitFull;
      str.incHi = advHi;
    end else begin
      hitLo     = cntEn && eqLo && !wrLo;
      hitHi     = cntEn && eqHi && !wrHi;
      advHi     = hitLo;
      str.clrLo = hitLo;
      str.clrHi = hitHi;
      str.incLo = cntEn && !hitLo;
      str.incHi = cntEn && !hitHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchLo  <= 1'b0;
      matchHi  <= 1'b0;
      irq      <= 1'b0;
      stageClk <= 1'b0;
    end else begin
      matchLo  <= hitLo;
      matchHi  <= hitHi || hitFull;
      irq      <= hitLo || hitHi || hitFull;
      stageClk <= advHi;
    end
  end

  // R3: a split-mode equality on an enabled edge gives a pulse
  p_match_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cascade && cntEn && eqLo && !wrLo) |=> matchLo);

  // R4: no enable, no pulses
  p_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (!matchLo && !matchHi && !irq && !stageClk));

  // R7: low-stage pulse is silent in cascade mode
  p_no_lo_cascade_r7: assert property (@(posedge clk) disable iff (!rstN)
    cascade |=> !matchLo);

  // R8: a write in the cycle of equality cancels that stage's pulse
  p_cancel_lo_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cascade && wrLo) |=> !matchLo);

  p_cancel_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cascade && (wrLo || wrHi)) |=> !matchHi);

endmodule

// File: rtl/split_cmp_timer.sv
`timescale 1ns/1ps
module split_cmp_timer
  import sct_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cntEn,
  input  logic            cascade,
  input  logic            wrLo,
  input  logic            wrHi,
  input  logic [HI_W-1:0] wrData,
  output logic            matchLo,
  output logic            matchHi,
  output logic            irq,
  output logic            stageClk
);

  sctStrobe_t str;
  logic       eqLo, eqHi, topLo;

  sct_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntEn    (cntEn),
    .cascade  (cascade),
    .wrLo     (wrLo),
    .wrHi     (wrHi),
    .eqLo     (eqLo),
    .eqHi     (eqHi),
    .topLo    (topLo),
    .str      (str),
    .matchLo  (matchLo),
    .matchHi  (matchHi),
    .irq      (irq),
    .stageClk (stageClk)
  );

  sct_datapath #(.LO_W(LO_W), .HI_W(HI_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .str    (str),
    .wrData (wrData),
    .eqLo   (eqLo),
    .eqHi   (eqHi),
    .topLo  (topLo)
  );

endmodule

// File: tb/split_cmp_timer_test.sv
`timescale 1ns/1ps
module split_cmp_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntEn = 1'b0, cascade = 1'b0, wrLo = 1'b0, wrHi = 1'b0;
  logic [7:0] wrData = '0;
  logic       matchLo, matchHi, irq, stageClk;

  always #2.5 clk = ~clk;

  split_cmp_timer uut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .cascade(cascade),
    .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData),
    .matchLo(matchLo), .matchHi(matchHi), .irq(irq), .stageClk(stageClk)
  );

  typedef struct {
    bit    lo;
    bit    hi;
    bit    ir;
    bit    st;
    string tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // independent model state
  logic [3:0] mLo, cLo;
  logic [7:0] mHi, cHi;
  logic [7:0] lfsr = 8'hA5;

  task automatic modelReset();
    mLo = '0; mHi = '0; cLo = 4'hF; cHi = 8'hFF;  // R1 reset values
  endtask

  task automatic doReset(input string tag);
    for (int i = 0; i < 3; i++) begin
      exp_t e;
      @(negedge clk);
      rstN = 1'b0; cntEn = 0; wrLo = 0; wrHi = 0; wrData = '0;
      modelReset();
      e.lo = 0; e.hi = 0; e.ir = 0; e.st = 0; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic step(input bit en, input bit casc, input bit wl, input bit wh,
                      input logic [7:0] d, input string tag);
    exp_t e;
    logic [11:0] v, c;
    bit hL, hH, h;
    @(negedge clk);
    rstN = 1'b1; cntEn = en; cascade = casc; wrLo = wl; wrHi = wh; wrData = d;
    e.tag = tag;
    if (!casc) begin
      hL = en && (mLo == cLo) && !wl;
      hH = en && (mHi == cHi) && !wh;
      e.lo = hL; e.hi = hH; e.ir = hL || hH; e.st = hL;
      if (hL) mLo = '0; else if (en) mLo = mLo + 4'd1;
      if (hH) mHi = '0; else if (en) mHi = mHi + 8'd1;
    end else begin
      v = {mHi, mLo}; c = {cHi, cLo};
      h = en && (v == c) && !wl && !wh;
      e.lo = 0; e.hi = h; e.ir = h; e.st = en && !h && (mLo == 4'hF);
      if (h) v = '0; else if (en) v = v + 12'd1;
      {mHi, mLo} = v;
    end
    if (wl) cLo = d[3:0];
    if (wh) cHi = d;
    q.push_back(e);
  endtask

  function automatic bit nextEn();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[0] | lfsr[2];
  endfunction

  // monitor: one expected item per clock edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (matchLo !== e.lo) begin fails++; $display("FAIL %s matchLo actual %0b expected %0b", e.tag, matchLo, e.lo); end
        if (matchHi !== e.hi) begin fails++; $display("FAIL %s matchHi actual %0b expected %0b", e.tag, matchHi, e.hi); end
        if (irq !== e.ir)     begin fails++; $display("FAIL %s irq actual %0b expected %0b", e.tag, irq, e.ir); end
        if (stageClk !== e.st) begin fails++; $display("FAIL %s stageClk actual %0b expected %0b", e.tag, stageClk, e.st); end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, R1..R8 run incomplete: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset outputs and default compare values (periods 16 and 256)
    doReset("R1");
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, 8'h00, "R1");

    // R2: register writes, then R3 split periods 4 and 7
    step(0, 0, 1, 0, 8'h03, "R2");
    step(0, 0, 0, 1, 8'h06, "R2");
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 8'h00, "R3");

    // R4: irregular enable
    for (int i = 0; i < 80; i++) step(nextEn(), 0, 0, 0, 8'h00, "R4");

    // R5: equal periods give coinciding hits, one irq
    doReset("R1");
    step(0, 0, 1, 1, 8'h02, "R2");
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 8'h00, "R5");
    // R3: compare value zero hits every enabled edge
    step(0, 0, 1, 0, 8'h00, "R2");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 8'h00, "R3");
    step(0, 0, 1, 1, 8'h05, "R2");
    for (int i = 0; i < 40; i++) step(nextEn(), 0, 0, 0, 8'h00, "R5");

    // R8: split-mode writes exactly on hit cycles
    step(0, 0, 1, 1, 8'h03, "R2");
    for (int i = 0; i < 120; i++) begin
      bit wl, wh;
      wl = (mLo == cLo) && (i % 3 != 2);
      wh = (mHi == cHi) && (i % 2 == 0);
      step(1, 0, wl, wh, wl ? {4'h0, cLo} : cHi, "R8");
    end

    // R6: cascade mode, 12-bit value 0x25, period 38
    doReset("R1");
    step(0, 1, 1, 0, 8'h05, "R2");
    step(0, 1, 0, 1, 8'h02, "R2");
    for (int i = 0; i < 120; i++) step(1, 1, 0, 0, 8'h00, "R6");
    // R7: irregular enable across several 12-bit periods
    for (int i = 0; i < 160; i++) step(nextEn(), 1, 0, 0, 8'h00, "R7");
    // R7: 12-bit value zero
    step(0, 1, 1, 1, 8'h00, "R2");
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 8'h00, "R7");

    // R8: cascade cancel via either register
    step(0, 1, 1, 1, 8'h01, "R2");
    for (int i = 0; i < 150; i++) begin
      bit hit, wl, wh;
      hit = ({mHi, mLo} == {cHi, cLo});
      wl = hit && (i % 4 == 1);
      wh = hit && (i % 4 == 3);
      step(1, 1, wl, wh, wl ? {4'h0, cLo} : cHi, "R8");
    end

    step(0, 1, 0, 0, 8'h00, "R4");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule